// File: doc/BRIEF.md
# Stack Store-to-Load Forwarding Table

This block keeps a small associative record of recent stack stores. Each record pairs the store address with the physical register tag that holds the stored value. A later load to one of those addresses can then be treated as a register-to-register move that reuses the recorded tag, with no cache access. A load that finds no valid record reports a miss and goes down the normal memory path.

Three control inputs keep the table safe:
- **Runtime stack-pointer adjustment.** When the stack pointer moves by an amount known only at run time, static offset matching is no longer possible. The table stops reporting hits until an explicit re-sync input restores tracking.
- **Overlapping non-stack store.** Such a store removes any record at its address.
- **Context event.** A non-local jump or an exception unwind wipes every record at once.

The lookup is combinational in the same cycle as the load request. Every table update lands on the next clock edge. New stores fill the slots in circular order, so a full table replaces its oldest allocation. A store to an address that is already recorded rewrites that record where it sits.

Top module: `stk_fwd_table`

## Requirements
- R1: After reset the table holds no records, tracking is enabled and every load reports a miss.
- R2: A load in any cycle after an accepted store to the same address reports a hit (`ldHit`=1). `ldTag` carries the most recent tag stored to that address, in the same cycle as the request.
- R3: A load to an address with no valid record reports `ldHit`=0. `ldTag` is 0 whenever `ldHit` is 0.
- R4: An accepted store to an address that already has a valid record replaces that record's tag in place. It does not take a new slot and does not change the record's age.
- R5: An accepted store to a new address is written to the slot after the previous allocation, wrapping after DEPTH slots. The allocation order restarts at the first slot on every clear. Once DEPTH allocations have been made, the next one discards the oldest allocation, even if that record is still valid.
- R6: When a store and a load to the same address arrive in one cycle, the load sees the table as it was before that store.
- R7: An overlapping write (`aliasWrEn`) removes the record at `aliasWrAddr` from the next cycle, leaving other records intact. A store accepted in the same cycle to that address leaves a valid record holding the store's tag.
- R8: A context flush (`ctxFlush`) empties the whole table at the next edge. A store in the same cycle is dropped.
- R9: `spDynAdj` disables tracking from the next cycle. While tracking is disabled, every load misses and every store is dropped. A store in the same cycle as `spDynAdj` is also dropped.
- R10: `reSync` empties the table and re-enables tracking from the next cycle, unless `spDynAdj` is high in that cycle, in which case tracking stays disabled. A store in a `reSync` cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stWrEn | input | 1 | Stack store event |
| stWrAddr | input | ADDR_W | Stack store address |
| stWrTag | input | TAG_W | Physical register tag holding the stored value |
| ldReqEn | input | 1 | Load lookup request |
| ldReqAddr | input | ADDR_W | Load address |
| ldHit | output | 1 | Load matched a valid record |
| ldTag | output | TAG_W | Tag of the matching record, zero on a miss |
| aliasWrEn | input | 1 | Non-stack store overlapping the stack |
| aliasWrAddr | input | ADDR_W | Address of the overlapping store |
| spDynAdj | input | 1 | Stack pointer changed by a runtime-valued amount |
| ctxFlush | input | 1 | Context event: clear all records |
| reSync | input | 1 | Re-establish tracking, clearing the table |

## Verification
On every cycle, the assertions check the miss-after-event properties:
- no hit in the cycle after a flush, a re-sync or a runtime stack-pointer change;
- no hit on an address that an overlapping write has just removed, unless a store re-recorded it in that cycle;
- a zero tag on every miss.

Only the bench's cycle-accurate reference model can show the rest:
- the forwarded tag values;
- in-place updates that keep a record's age;
- circular replacement of the oldest allocation once the table is full;
- the before-store view for same-cycle store/load pairs;
- that tracking stays off across many cycles until a re-sync.

// File: rtl/stk_fwd_pkg.sv
package stk_fwd_pkg;
  // Strobes from the control half to the table storage.
  typedef struct packed {
    logic clrAll;     // wipe every record
    logic insNew;     // write a new record at the allocation slot
    logic insUpd;     // rewrite the tag of the matching record
    logic aliasKill;  // remove the record hit by an overlapping write
    logic lookOn;     // tracking enabled, loads may hit
  } fwdCtl_t;
endpackage

// File: rtl/stk_fwd_ctrl.sv
module stk_fwd_ctrl
  import stk_fwd_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stWrEn,
  input  logic             stHitAny,
  input  logic             aliasWrEn,
  input  logic             spDynAdj,
  input  logic             ctxFlush,
  input  logic             reSync,
  output fwdCtl_t          ctl,
  output logic [IDX_W-1:0] allocIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             trackOn;
  logic [IDX_W-1:0] wrPtr;
  logic             clrNow;
  logic             acceptSt;

  always_comb begin
    clrNow        = ctxFlush | reSync;
    acceptSt      = stWrEn & trackOn & ~spDynAdj & ~clrNow;
    ctl.clrAll    = clrNow;
    ctl.insUpd    = acceptSt & stHitAny;
    ctl.insNew    = acceptSt & ~stHitAny;
    ctl.aliasKill = aliasWrEn & ~clrNow;
    ctl.lookOn    = trackOn;
  end

  assign allocIdx = wrPtr;

  // Tracking state: lost on a runtime stack-pointer change, restored by re-sync.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         trackOn <= 1'b1;
    else if (spDynAdj) trackOn <= 1'b0;
    else if (reSync)   trackOn <= 1'b1;
  end

  // Circular allocation pointer, restarted on every clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wrPtr <= '0;
    else if (clrNow)     wrPtr <= '0;
    else if (ctl.insNew) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
  end
endmodule

// File: rtl/stk_fwd_store.sv
module stk_fwd_store
  import stk_fwd_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwdCtl_t           ctl,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [ADDR_W-1:0] stWrAddr,
  input  logic [TAG_W-1:0]  stWrTag,
  input  logic              ldReqEn,
  input  logic [ADDR_W-1:0] ldReqAddr,
  input  logic [ADDR_W-1:0] aliasWrAddr,
  output logic              stHitAny,
  output logic              ldHit,
  output logic [TAG_W-1:0]  ldTag
);
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [TAG_W-1:0]  entTag  [DEPTH];
  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  stMatch, ldMatch, alMatch, wrSel;
  logic [TAG_W-1:0]  tagOr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign stMatch[i] = entValid[i] && (entAddr[i] == stWrAddr);
    assign ldMatch[i] = entValid[i] && (entAddr[i] == ldReqAddr);
    assign alMatch[i] = entValid[i] && (entAddr[i] == aliasWrAddr);
    assign wrSel[i]   = (ctl.insUpd & stMatch[i]) |
                        (ctl.insNew & (allocIdx == IDX_W'(i)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entAddr[i]  <= '0;
        entTag[i]   <= '0;
      end else if (ctl.clrAll) begin
        entValid[i] <= 1'b0;
      end else begin
        entValid[i] <= (entValid[i] & ~(ctl.aliasKill & alMatch[i])) | wrSel[i];
        if (wrSel[i]) begin
          entAddr[i] <= stWrAddr;
          entTag[i]  <= stWrTag;
        end
      end
    end
  end

  // At most one valid record matches an address, so an OR-reduce selects it.
  always_comb begin
    tagOr = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ldMatch[k]) tagOr = tagOr | entTag[k];
    end
  end

  assign stHitAny = |stMatch;
  assign ldHit    = ldReqEn & ctl.lookOn & (|ldMatch);
  assign ldTag    = ldHit ? tagOr : '0;
endmodule

// File: rtl/stk_fwd_table.sv
module stk_fwd_table
  import stk_fwd_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stWrEn,
  input  logic [ADDR_W-1:0] stWrAddr,
  input  logic [TAG_W-1:0]  stWrTag,
  input  logic              ldReqEn,
  input  logic [ADDR_W-1:0] ldReqAddr,
  output logic              ldHit,
  output logic [TAG_W-1:0]  ldTag,
  input  logic              aliasWrEn,
  input  logic [ADDR_W-1:0] aliasWrAddr,
  input  logic              spDynAdj,
  input  logic              ctxFlush,
  input  logic              reSync
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  fwdCtl_t          ctl;
  logic [IDX_W-1:0] allocIdx;
  logic             stHitAny;

  stk_fwd_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .stWrEn(stWrEn), .stHitAny(stHitAny),
    .aliasWrEn(aliasWrEn), .spDynAdj(spDynAdj), .ctxFlush(ctxFlush),
    .reSync(reSync), .ctl(ctl), .allocIdx(allocIdx)
  );

  stk_fwd_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .allocIdx(allocIdx),
    .stWrAddr(stWrAddr), .stWrTag(stWrTag), .ldReqEn(ldReqEn),
    .ldReqAddr(ldReqAddr), .aliasWrAddr(aliasWrAddr),
    .stHitAny(stHitAny), .ldHit(ldHit), .ldTag(ldTag)
  );
endmodule

// File: rtl/stk_fwd_chk.sv
module stk_fwd_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stWrEn,
  input logic [ADDR_W-1:0] stWrAddr,
  input logic              ldReqEn,
  input logic [ADDR_W-1:0] ldReqAddr,
  input logic              ldHit,
  input logic [TAG_W-1:0]  ldTag,
  input logic              aliasWrEn,
  input logic [ADDR_W-1:0] aliasWrAddr,
  input logic              spDynAdj,
  input logic              ctxFlush,
  input logic              reSync
);
  // R3: a miss never carries a tag
  a_r3_zero_tag_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    !ldHit |-> (ldTag == '0));

  // R3: a hit only answers a real request
  a_r3_hit_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    ldHit |-> ldReqEn);

  // R8: after a flush the table is empty
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctxFlush |=> !ldHit);

  // R9: tracking lost after a runtime stack-pointer change
  a_r9_dyn_adj_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    spDynAdj |=> !ldHit);

  // R10: re-sync clears every record
  a_r10_resync_empties: assert property (@(posedge clk) disable iff (!rstN)
    reSync |=> !ldHit);

  // R7: a removed address misses unless a store re-recorded it the same cycle
  a_r7_alias_kills: assert property (@(posedge clk) disable iff (!rstN)
    (aliasWrEn && !(stWrEn && stWrAddr == aliasWrAddr)) |=>
      !(ldHit && ldReqAddr == $past(aliasWrAddr)));
endmodule

bind stk_fwd_table stk_fwd_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .stWrEn(stWrEn), .stWrAddr(stWrAddr),
  .ldReqEn(ldReqEn), .ldReqAddr(ldReqAddr), .ldHit(ldHit), .ldTag(ldTag),
  .aliasWrEn(aliasWrEn), .aliasWrAddr(aliasWrAddr), .spDynAdj(spDynAdj),
  .ctxFlush(ctxFlush), .reSync(reSync)
);

// File: tb/stk_fwd_table_tb_top.sv
`timescale 1ns/100ps
module stk_fwd_table_tb_top;
  localparam int DEPTH  = 24;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              stWrEn = 0, ldReqEn = 0, aliasWrEn = 0;
  logic              spDynAdj = 0, ctxFlush = 0, reSync = 0;
  logic [ADDR_W-1:0] stWrAddr = '0, ldReqAddr = '0, aliasWrAddr = '0;
  logic [TAG_W-1:0]  stWrTag = '0;
  logic              ldHit;
  logic [TAG_W-1:0]  ldTag;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  stk_fwd_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .stWrEn(stWrEn), .stWrAddr(stWrAddr),
    .stWrTag(stWrTag), .ldReqEn(ldReqEn), .ldReqAddr(ldReqAddr),
    .ldHit(ldHit), .ldTag(ldTag), .aliasWrEn(aliasWrEn),
    .aliasWrAddr(aliasWrAddr), .spDynAdj(spDynAdj), .ctxFlush(ctxFlush),
    .reSync(reSync)
  );

  // Behavioural reference: records kept in allocation order.
  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [TAG_W-1:0]  t;
    bit                v;
  } rec_t;
  rec_t mq[$];
  bit   mTrack = 1;

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit               expHit;
      logic [TAG_W-1:0] expTag;
      bit               clr;
      bit               acc;
      int               found;
      expHit = 0;
      expTag = '0;
      if (ldReqEn && mTrack) begin
        foreach (mq[i]) if (mq[i].v && mq[i].a == ldReqAddr) begin
          expHit = 1;
          expTag = mq[i].t;
        end
      end
      checks++;
      if (ldHit !== expHit || ldTag !== expTag) begin
        failures++;
        $display("FAIL %s addr=%h hit=%0b tag=%0d expected hit=%0b tag=%0d",
                 curReq, ldReqAddr, ldHit, ldTag, expHit, expTag);
      end
      // apply this cycle's events to the model
      clr = ctxFlush || reSync;
      acc = stWrEn && mTrack && !spDynAdj && !clr;
      if (clr) begin
        mq.delete();
      end else begin
        found = -1;
        if (acc) foreach (mq[i]) if (mq[i].v && mq[i].a == stWrAddr) found = i;
        if (aliasWrEn) foreach (mq[i]) if (mq[i].v && mq[i].a == aliasWrAddr) mq[i].v = 0;
        if (acc) begin
          if (found >= 0) begin
            mq[found].t = stWrTag;
            mq[found].v = 1;
          end else begin
            rec_t r;
            r.a = stWrAddr;
            r.t = stWrTag;
            r.v = 1;
            mq.push_back(r);
            if (mq.size() > DEPTH) void'(mq.pop_front());
          end
        end
      end
      if (spDynAdj)    mTrack = 0;
      else if (reSync) mTrack = 1;
    end
  end

  task automatic cyc(input bit st, input logic [ADDR_W-1:0] sa, input int stg,
                     input bit ld, input logic [ADDR_W-1:0] la,
                     input bit al = 0, input logic [ADDR_W-1:0] aa = '0,
                     input bit dyn = 0, input bit fl = 0, input bit rs = 0);
    @(posedge clk);
    #1;
    stWrEn = st; stWrAddr = sa; stWrTag = TAG_W'(stg);
    ldReqEn = ld; ldReqAddr = la;
    aliasWrEn = al; aliasWrAddr = aa;
    spDynAdj = dyn; ctxFlush = fl; reSync = rs;
  endtask

  task automatic idle();
    cyc(0, '0, 0, 0, '0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          done = 1;
          $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: empty after reset
    curReq = "R1";
    cyc(0, '0, 0, 1, 32'h40);
    cyc(0, '0, 0, 1, 32'h0);
    // R2 / R3: basic forward and miss
    curReq = "R2";
    cyc(1, 32'h40, 5, 0, '0);
    cyc(0, '0, 0, 1, 32'h40);
    curReq = "R3";
    cyc(0, '0, 0, 1, 32'h44);
    // R6: same-cycle store and load
    curReq = "R6";
    cyc(1, 32'h48, 7, 1, 32'h48);
    cyc(0, '0, 0, 1, 32'h48);
    cyc(1, 32'h48, 8, 1, 32'h48);
    cyc(0, '0, 0, 1, 32'h48);
    // R4: in-place update
    curReq = "R4";
    cyc(1, 32'h40, 9, 1, 32'h40);
    cyc(0, '0, 0, 1, 32'h40);
    // R8: flush, with a same-cycle store dropped
    curReq = "R8";
    cyc(1, 32'h4c, 3, 0, '0, 0, '0, 0, 1, 0);
    cyc(0, '0, 0, 1, 32'h40);
    cyc(0, '0, 0, 1, 32'h4c);
    // R5: fill, update the oldest, then one more allocation evicts it
    curReq = "R5";
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'h100 + 4*i, 10 + i, 0, '0);
    for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 1, 32'h100 + 4*i);
    curReq = "R4";
    cyc(1, 32'h100, 99, 0, '0);
    cyc(0, '0, 0, 1, 32'h100);
    curReq = "R5";
    cyc(1, 32'h200, 77, 0, '0);
    cyc(0, '0, 0, 1, 32'h100);
    cyc(0, '0, 0, 1, 32'h104);
    cyc(0, '0, 0, 1, 32'h200);
    cyc(1, 32'h204, 78, 1, 32'h104);
    cyc(0, '0, 0, 1, 32'h104);
    // R7: overlapping write removal, and same-cycle re-record
    curReq = "R7";
    cyc(0, '0, 0, 0, '0, 1, 32'h108);
    cyc(0, '0, 0, 1, 32'h108);
    cyc(0, '0, 0, 1, 32'h10c);
    cyc(1, 32'h10c, 55, 0, '0, 1, 32'h10c);
    cyc(0, '0, 0, 1, 32'h10c);
    // R9: runtime stack-pointer change
    curReq = "R9";
    cyc(1, 32'h300, 21, 0, '0);
    cyc(0, '0, 0, 1, 32'h300);
    cyc(1, 32'h304, 22, 0, '0, 0, '0, 1, 0, 0);
    cyc(0, '0, 0, 1, 32'h300);
    cyc(0, '0, 0, 1, 32'h304);
    cyc(1, 32'h308, 23, 0, '0);
    cyc(0, '0, 0, 1, 32'h308);
    // R10: re-sync together with a stack-pointer change keeps tracking off
    curReq = "R10";
    cyc(0, '0, 0, 0, '0, 0, '0, 1, 0, 1);
    cyc(1, 32'h30c, 24, 0, '0);
    cyc(0, '0, 0, 1, 32'h30c);
    cyc(1, 32'h310, 25, 0, '0, 0, '0, 0, 0, 1);
    cyc(1, 32'h310, 26, 1, 32'h310);
    cyc(0, '0, 0, 1, 32'h310);
    cyc(0, '0, 0, 1, 32'h300);
    // Mixed traffic over a small address pool
    curReq = "R2";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc($urandom_range(0, 1), 32'h400 + 4*$urandom_range(0, 31), $urandom_range(1, 255),
          $urandom_range(0, 1), 32'h400 + 4*$urandom_range(0, 31),
          r < 8, 32'h400 + 4*$urandom_range(0, 31),
          r == 8, r == 9, r >= 10 && r < 12);
    end
    idle();
    idle();
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule